// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Bank

This block keeps the configuration for four open-drain I/O pins in registers that each have two copies. The working copy drives the pins. The backing copy survives power loss and is modelled as a register array with a timed write. A byte-wide request port reads and writes the bank. The pin outputs are two vectors: one enables the pullups and one enables the pulldowns. A readback of the live pin levels is also provided.

A mode bit picks how writes to the shadowed bytes behave. When the mode bit is set, such a write changes only the working copy and takes effect at once. When it is clear, the write also goes into a page buffer. After the transaction ends, that buffer is written into backing storage as one whole 8-byte page, and a busy flag covers the write time. The 64 user bytes always take the committed path. A small scratch area is always volatile. After reset, the block recalls the shadowed page from backing storage into the working copies, and the pin drivers stay released until that recall is complete.

Top module: `nvbank_top`

## Requirements
- R1: One cycle after reset is released, the working copies at F0h..F7h equal the backing page. The factory contents are F1h=03h, F4h..F7h=01h, and 00h everywhere else in the shadowed page and the user bytes. busy is low from then on while no commit is pending.
- R2: From the start of reset until the recall has completed, pullup_en and pulldown_en are both 0000b, whatever the backing page holds.
- R3: Bit i of pullup_en follows bit i of F0h. pulldown_en[3], [2], [1] and [0] are driven high when bit 0 of F4h, F5h, F6h and F7h respectively is zero.
- R4: A read of F8h returns {0000b, pin_in}, and a write to F8h has no effect.
- R5: With the mode bit (F9h bit 0, reset value 0) set to one, a write to F0h..F7h updates the working copy and pins at once. It starts no commit, and the backing page keeps its old value, so the old value returns after reset.
- R6: With the mode bit at zero, a write to F0h..F7h takes effect at once. A txn_end that follows raises busy on the next cycle for exactly COMMIT_CYCLES cycles, and the value is then held in backing storage across reset.
- R7: Writes to 00h..3Fh are committed whatever the mode bit says. Reads there return backing contents, so a new value becomes readable only once its commit has finished.
- R8: A commit rewrites the whole 8-byte page. Bytes of that page that the transaction did not write keep their previous values.
- R9: Within one transaction, every committed write lands in the page of the first committed write, at byte offset addr[2:0]. For example, writes to 1Eh, 1Fh and 20h go to 1Eh, 1Fh and 18h.
- R10: While busy is high, write requests are rejected. They change neither the working copies nor backing storage.
- R11: FAh..FFh read back what was written and clear to 00h on reset. Addresses 40h..EFh read 00h and ignore writes.
- R12: A txn_end with no pending committed write leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| req_valid | input | 1 | Request strobe, one cycle per byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write data |
| txn_end | input | 1 | End-of-transaction pulse; starts a pending commit |
| rd_data | output | 8 | Read data for req_addr, combinational |
| busy | output | 1 | Recall or commit in progress; writes rejected |
| pin_in | input | 4 | Sampled pin levels |
| pullup_en | output | 4 | Pullup enables, pin 3..0 |
| pulldown_en | output | 4 | Pulldown enables, pin 3..0 |

## Verification
The bench first commits values that enable pullups and pulldowns, then resets. This exposes a design that drives the pins from stale working copies during the recall cycle. It counts the busy cycles after txn_end one by one, so a timer that is off by one, or that fails to start, is caught. A three-byte write that crosses a page boundary shows whether the design incorrectly spills into the next page instead of wrapping. A single-byte rewrite of a filled page shows whether a design that clears the unwritten bytes loses data. Writes during busy, and shadow writes in volatile mode followed by a reset, show whether a design wrongly lets volatile or rejected writes reach backing storage.

// File: rtl/nvbank_pkg.sv
// Shared constants for the shadowed register bank: address regions,
// page geometry and factory contents of the shadowed page.
package nvbank_pkg;
    localparam int BYTE_W      = 8;
    localparam int PAGE_BYTES  = 8;
    localparam int USER_PAGES  = 8;
    localparam int NUM_PAGES   = USER_PAGES + 1;     // last page is the shadowed one
    localparam int PAGE_IDX_W  = $clog2(NUM_PAGES);
    localparam int NUM_PINS    = 4;

    localparam logic [4:0] SHADOW_HI   = 5'b11110;   // F0h..F7h
    localparam logic [7:0] USER_END    = 8'h40;
    localparam logic [7:0] ADDR_STATUS = 8'hF8;
    localparam logic [7:0] ADDR_MODE   = 8'hF9;
    localparam logic [7:0] SCR_FIRST   = 8'hFA;

    localparam logic [PAGE_IDX_W-1:0] SHADOW_PAGE = PAGE_IDX_W'(NUM_PAGES - 1);

    typedef logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_t;

    // Factory contents of the shadowed page: delay 03h, pin controls 01h.
    function automatic page_t factory_shadow();
        page_t p;
        p = '0;
        p[1] = 8'h03;
        for (int i = 4; i < 8; i++) p[i] = 8'h01;
        return p;
    endfunction
endpackage

// File: rtl/nvbank_store.sv
// Backing storage model: NUM_PAGES pages of 8 bytes, written a whole page
// at a time. Not cleared by reset; holds factory contents from time zero.
// Assumes the caller issues at most one page write per cycle.
module nvbank_store
    import nvbank_pkg::*;
(
    input  logic                  clk,
    input  logic [PAGE_IDX_W-1:0] rd_idx,
    output page_t                 rd_page,
    output page_t                 shadow_page,
    input  logic                  wr_en,
    input  logic [PAGE_IDX_W-1:0] wr_idx,
    input  page_t                 wr_page
);
    page_t mem [NUM_PAGES];

    // Factory programming of the storage array.
    initial begin
        for (int p = 0; p < NUM_PAGES - 1; p++) mem[p] = '0;
        mem[NUM_PAGES-1] = factory_shadow();
    end

    // Whole-page write at the end of a commit.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_page;
    end

    assign rd_page     = mem[rd_idx];
    assign shadow_page = mem[NUM_PAGES-1];
endmodule

// File: rtl/nvbank_timer.sv
// Commit write-time counter: busy for exactly CYCLES clocks after start,
// with a done pulse in the last busy cycle. Assumes start only when idle.
module nvbank_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (start && !busy)    cnt_q <= CW'(CYCLES);
        else if (busy)              cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CYCLES)); // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy); // R6
endmodule

// File: rtl/nvbank_top.sv
// Shadowed register bank: working copies for the pin controls and shadowed
// bytes, a page buffer for committed writes, recall after reset, and
// whole-page commit after txn_end. Assumes txn_end follows the last
// request of a transaction, and that rd_data is sampled combinationally.
module nvbank_top
    import nvbank_pkg::*;
#(
    parameter int COMMIT_CYCLES = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [BYTE_W-1:0]   req_addr,
    input  logic [BYTE_W-1:0]   req_wdata,
    input  logic                txn_end,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                busy,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pullup_en,
    output logic [NUM_PINS-1:0] pulldown_en
);
    logic                  mode_q;        // 1 = volatile shadow writes
    logic                  recall_q;
    page_t                 work_q;
    logic [BYTE_W-1:0]     scr_q [PAGE_BYTES];
    logic                  pend_q;
    logic [PAGE_IDX_W-1:0] pend_page_q;
    page_t                 pbuf_q;
    page_t                 page_rd, shadow_rd, first_buf;
    logic                  t_busy, t_done, t_start;
    logic                  is_user, is_shadow, commit_cls, wr_ok;
    logic [BYTE_W-1:0]     eff_addr;
    logic [PAGE_IDX_W-1:0] req_page;

    // Address classification and page redirection for committed writes.
    always_comb begin
        is_user    = (req_addr < USER_END);
        is_shadow  = (req_addr[7:3] == SHADOW_HI);
        commit_cls = is_user || (is_shadow && !mode_q);
        req_page   = is_shadow ? SHADOW_PAGE : PAGE_IDX_W'(req_addr[5:3]);
        if (pend_q && commit_cls)
            eff_addr = (pend_page_q == SHADOW_PAGE)
                     ? {SHADOW_HI, req_addr[2:0]}
                     : {2'b00, pend_page_q[2:0], req_addr[2:0]};
        else
            eff_addr = req_addr;
        first_buf = page_rd;
        first_buf[req_addr[2:0]] = req_wdata;
    end

    assign busy    = t_busy || recall_q;
    assign wr_ok   = req_valid && req_write && !busy;
    assign t_start = txn_end && pend_q && !busy;

    // Working copies, mode bit, scratch bytes and post-reset recall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recall_q <= 1'b1;
            mode_q   <= 1'b0;
            work_q   <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) scr_q[i] <= '0;
        end else if (recall_q) begin
            work_q   <= shadow_rd;
            recall_q <= 1'b0;
        end else if (wr_ok) begin
            if (eff_addr[7:3] == SHADOW_HI) work_q[eff_addr[2:0]] <= req_wdata;
            if (req_addr == ADDR_MODE)      mode_q <= req_wdata[0];
            if (req_addr >= SCR_FIRST)      scr_q[req_addr[2:0]] <= req_wdata;
        end
    end

    // Page buffer collecting committed writes of the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_page_q <= '0;
            pbuf_q      <= '0;
        end else if (t_done) begin
            pend_q <= 1'b0;
        end else if (wr_ok && commit_cls) begin
            if (!pend_q) begin
                pbuf_q      <= first_buf;
                pend_q      <= 1'b1;
                pend_page_q <= req_page;
            end else begin
                pbuf_q[eff_addr[2:0]] <= req_wdata;
            end
        end
    end

    // Read multiplexer over all address regions.
    always_comb begin
        if (is_user)                    rd_data = page_rd[req_addr[2:0]];
        else if (is_shadow)             rd_data = work_q[req_addr[2:0]];
        else if (req_addr == ADDR_STATUS) rd_data = {4'b0000, pin_in};
        else if (req_addr == ADDR_MODE) rd_data = {7'b0, mode_q};
        else if (req_addr >= SCR_FIRST) rd_data = scr_q[req_addr[2:0]];
        else                            rd_data = '0;
    end

    // Pin drive from working copies, released until recall completes.
    assign pullup_en = recall_q ? '0 : work_q[0][NUM_PINS-1:0];
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pd
        assign pulldown_en[g] = !recall_q && !work_q[7-g][0];
    end

    nvbank_store u_store (
        .clk        (clk),
        .rd_idx     (req_page),
        .rd_page    (page_rd),
        .shadow_page(shadow_rd),
        .wr_en      (t_done),
        .wr_idx     (pend_page_q),
        .wr_page    (pbuf_q)
    );

    nvbank_timer #(.CYCLES(COMMIT_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(t_start),
        .busy (t_busy),
        .done (t_done)
    );

    AST_COMMIT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_end && pend_q && !busy) |=> t_busy); // R6
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (t_busy && req_valid && req_write) |=> $stable(work_q)); // R10
    AST_IDLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_end && !pend_q && !busy) |=> !busy); // R12
    AST_STATUS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr == ADDR_STATUS) |-> (rd_data[7:4] == 4'b0000)); // R4
    AST_RECALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pullup_en == '0 && pulldown_en == '0)); // R2
endmodule

// File: tb/nvbank_top_tb.sv
// Directed bench for nvbank_top: one task per scenario, each self-checking.
module nvbank_top_tb;
    localparam int CLK_P = 10;
    localparam int NCYC  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, txn_end = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic [3:0] pin_in = 4'h0;
    logic [7:0] rd_data;
    logic       busy;
    logic [3:0] pullup_en, pulldown_en;
    int total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;

    nvbank_top #(.COMMIT_CYCLES(NCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .txn_end(txn_end),
        .rd_data(rd_data), .busy(busy), .pin_in(pin_in),
        .pullup_en(pullup_en), .pulldown_en(pulldown_en)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        req_addr = a;
        #1 check(req, rd_data, exp);
    endtask

    task automatic end_txn();
        @(negedge clk); txn_end = 1'b1;
        @(negedge clk); txn_end = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
    endtask

    // Reset; returns after recall with the pin drive checked during recall.
    task automatic do_reset(input string req);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 check({req, " pins released"}, {pullup_en, pulldown_en}, 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset("R2");
        check("R1 busy", busy, 0);
        rd_chk("R1 F1", 8'hF1, 8'h03);
        rd_chk("R1 F4", 8'hF4, 8'h01);
        rd_chk("R1 F7", 8'hF7, 8'h01);
        rd_chk("R1 F0", 8'hF0, 8'h00);
        rd_chk("R1 user", 8'h05, 8'h00);
        check("R3 idle pins", {pullup_en, pulldown_en}, 0);
    endtask

    task automatic t_volatile();
        wr(8'hF9, 8'h01);
        rd_chk("R5 mode", 8'hF9, 8'h01);
        wr(8'hF0, 8'h05);
        wr(8'hF5, 8'h00);
        end_txn();
        check("R12 no commit", busy, 0);
        check("R3 pullup", pullup_en, 4'h5);
        check("R3 pulldown F5", pulldown_en, 4'b0100);
        rd_chk("R5 F0 work", 8'hF0, 8'h05);
        do_reset("R2");
        rd_chk("R5 F0 restored", 8'hF0, 8'h00);
        check("R5 pins restored", {pullup_en, pulldown_en}, 0);
        rd_chk("R5 mode reset", 8'hF9, 8'h00);
    endtask

    task automatic t_status();
        pin_in = 4'hA;
        rd_chk("R4 status", 8'hF8, 8'h0A);
        wr(8'hF8, 8'hFF);
        rd_chk("R4 write ignored", 8'hF8, 8'h0A);
        pin_in = 4'h0;
    endtask

    task automatic t_commit();
        int n;
        wr(8'hF0, 8'h0F);
        wr(8'hF4, 8'h00);
        rd_chk("R6 F0 immediate", 8'hF0, 8'h0F);
        check("R6 pins immediate", {pullup_en, pulldown_en}, 8'hF8);
        end_txn();
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check("R6 busy cycles", n, NCYC);
        end_txn();
        check("R12 idle end", busy, 0);
        do_reset("R2 after commit");
        check("R6 pullup kept", pullup_en, 4'hF);
        check("R6 pulldown kept", pulldown_en, 4'b1000);
        // restore factory value of F4 and F0
        wr(8'hF0, 8'h00); wr(8'hF4, 8'h01); end_txn(); wait_idle();
    endtask

    task automatic t_reject();
        wr(8'hF2, 8'h11); end_txn();
        check("R10 busy", busy, 1);
        wr(8'hF2, 8'hAA);
        wr(8'h08, 8'hBB);
        wait_idle();
        rd_chk("R10 work unchanged", 8'hF2, 8'h11);
        rd_chk("R10 user unchanged", 8'h08, 8'h00);
    endtask

    task automatic t_user();
        wr(8'hF9, 8'h01);
        wr(8'h12, 8'h5A);
        rd_chk("R7 old before commit", 8'h12, 8'h00);
        end_txn();
        check("R7 commits in volatile mode", busy, 1);
        wait_idle();
        rd_chk("R7 new after commit", 8'h12, 8'h5A);
        wr(8'h13, 8'h77); end_txn(); wait_idle();
        rd_chk("R8 neighbour kept", 8'h12, 8'h5A);
        rd_chk("R8 written byte", 8'h13, 8'h77);
        rd_chk("R8 untouched", 8'h14, 8'h00);
    endtask

    task automatic t_wrap();
        wr(8'h1E, 8'h11); wr(8'h1F, 8'h22); wr(8'h20, 8'h33);
        end_txn(); wait_idle();
        rd_chk("R9 1E", 8'h1E, 8'h11);
        rd_chk("R9 1F", 8'h1F, 8'h22);
        rd_chk("R9 wrapped 18", 8'h18, 8'h33);
        rd_chk("R9 next page untouched", 8'h20, 8'h00);
    endtask

    task automatic t_scratch();
        wr(8'hFA, 8'hC3); wr(8'hFF, 8'h3C);
        rd_chk("R11 FA", 8'hFA, 8'hC3);
        rd_chk("R11 FF", 8'hFF, 8'h3C);
        wr(8'h80, 8'hFF);
        rd_chk("R11 reserved", 8'h80, 8'h00);
        do_reset("R2");
        rd_chk("R11 FA cleared", 8'hFA, 8'h00);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_volatile();
        t_status();
        t_commit();
        t_reject();
        t_user();
        t_wrap();
        t_scratch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule